// File: doc/BRIEF.md
# Link Status Interrupt Aggregator

This block watches the health of four independent receive channels and folds every noteworthy change into one shared, active-low interrupt line. Each channel supplies a signal-present flag, a lock flag and eye-opening measurements (horizontal and vertical, with a valid strobe) from analog and measurement logic outside the block. Two loss events are always live: signal going away after it had been present, and lock dropping after it had been held. A third event, the eye-opening alarm, is enabled per channel and fires when a valid measurement falls strictly below that channel's programmed thresholds.

Every event is recorded in a sticky per-channel cause register that the host reads and clears with write-one-to-clear over a small register bus (single-cycle write, read data one clock after the request). The interrupt output is an open-drain drive enable. While any cause bit is set, the enable is high and the pad pulls the shared wire low. Otherwise the pad is released, so the interrupts of several devices can be wired together.

Top module: `link_irq_agg`

## Requirements
- R1: The four channels are independent: an event on one channel sets cause bits only in that channel's status register.
- R2: The loss-of-signal cause (status bit 0) is set only when `sig_det` is sampled 1 on one clock edge and 0 on the next. A channel whose `sig_det` has been low since reset records no loss.
- R3: The loss-of-lock cause (status bit 1) is set only when `lock_det` is sampled 1 on one clock edge and 0 on the next. It re-arms only after lock has been sampled high again.
- R4: The loss-of-signal and loss-of-lock causes are recorded whatever the value of the eye-alarm enable.
- R5: The eye-alarm enable is bit 16 of a channel's config register and resets to 0. While it is 0, the eye cause (status bit 2) is never set.
- R6: An eye event needs a cycle with `eye_vld` high and either the horizontal value below config bits [7:0] or the vertical value below config bits [15:8], both compared as unsigned and strictly. It fires only on the first failing valid measurement after reset or after a passing valid measurement. Cycles with `eye_vld` low change nothing.
- R7: Cause bits are sticky. Writing 1 to a bit of a status register clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear of that bit leaves the bit set.
- R8: `irq_n_oe` is high exactly while at least one cause bit of any channel is set. When high, the pad drives the shared line low, and after reset it is 0 (line released).
- R9: Register map: channel c's config is at address 2c, its status at 2c+1, and address 8 is a read-only summary whose bit c is the OR of channel c's causes. A read returns the pre-write contents one clock after `bus_re`. Unmapped addresses read 0, and writes to the summary are ignored. All registers reset to 0.
- R10: Each channel's horizontal and vertical thresholds are held separately. A threshold of 0 can never be failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sig_det | input | 4 | Per-channel signal-present flag |
| lock_det | input | 4 | Per-channel lock flag |
| eye_h | input | 32 | Horizontal eye opening, 8 bits per channel (channel c at [8c+7:8c]) |
| eye_v | input | 32 | Vertical eye opening, 8 bits per channel |
| eye_vld | input | 4 | Per-channel measurement valid strobe |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after `bus_re` |
| irq_n_oe | output | 1 | Open-drain drive enable: 1 pulls the shared interrupt line low |

## Verification
The bench goes after the signal that is low from reset, which must not count as a loss. A design without the was-good qualification would raise an interrupt at start-up. It also aims a clear and a fresh event at the same bit in the same cycle, where a clear-first design loses the event. For the eye alarm it tries measurements equal to the thresholds, which a non-strict compare would flag, and repeated failing measurements, which a level-sensitive design would keep re-raising after every clear. It also checks that invalid cycles are ignored, that the enable gates only the eye cause, and that a threshold of zero never trips. Random toggling of all four channels, mixed with random clears and reads, is scored against a cycle-accurate model.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
  localparam int EYE_W  = 8;
  localparam int CFG_W  = 2 * EYE_W + 1;
  localparam int STAT_W = 3;

  typedef struct packed {
    logic             eye_en;
    logic [EYE_W-1:0] v_thr;
    logic [EYE_W-1:0] h_thr;
  } chan_cfg_t;

  typedef struct packed {
    logic eye;
    logic lol;
    logic los;
  } chan_stat_t;
endpackage

// File: rtl/link_loss_watch.sv
module link_loss_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  output logic loss_evt
);
  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d  = det;
    loss_evt = armed_q & ~det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/link_eye_watch.sv
module link_eye_watch #(
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          vld,
  input  logic [EW-1:0] h_val,
  input  logic [EW-1:0] v_val,
  input  logic [EW-1:0] h_thr,
  input  logic [EW-1:0] v_thr,
  output logic          eye_evt
);
  logic bad_q;
  logic bad_d;
  logic fail;
  logic bad_upd;

  always_comb begin
    fail    = (h_val < h_thr) | (v_val < v_thr);
    bad_upd = vld;
    bad_d   = bad_upd ? fail : bad_q;
    eye_evt = en & vld & fail & ~bad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bad_q <= 1'b0;
    else if (bad_upd) bad_q <= bad_d;
  end
endmodule

// File: rtl/link_chan_mon.sv
module link_chan_mon
  import link_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_det,
  input  logic             lock_det,
  input  logic             eye_vld,
  input  logic [EYE_W-1:0] eye_h,
  input  logic [EYE_W-1:0] eye_v,
  input  chan_cfg_t        cfg,
  input  chan_stat_t       clr,
  output chan_stat_t       stat
);
  chan_stat_t evt;
  chan_stat_t stat_q;
  chan_stat_t stat_d;
  logic       stat_upd;

  link_loss_watch u_sig (
    .clk      (clk),
    .rst_n    (rst_n),
    .det      (sig_det),
    .loss_evt (evt.los)
  );

  link_loss_watch u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .det      (lock_det),
    .loss_evt (evt.lol)
  );

  link_eye_watch #(.EW(EYE_W)) u_eye (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.eye_en),
    .vld     (eye_vld),
    .h_val   (eye_h),
    .v_val   (eye_v),
    .h_thr   (cfg.h_thr),
    .v_thr   (cfg.v_thr),
    .eye_evt (evt.eye)
  );

  always_comb begin
    stat_upd = (|evt) | (|(stat_q & clr));
    stat_d   = chan_stat_t'(evt | (stat_q & ~clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_q <= '0;
    else if (stat_upd) stat_q <= stat_d;
  end

  assign stat = stat_q;
endmodule

// File: rtl/link_reg_file.sv
module link_reg_file
  import link_irq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  input  chan_stat_t [NCH-1:0]  stat,
  output chan_cfg_t  [NCH-1:0]  cfg,
  output chan_stat_t [NCH-1:0]  clr,
  output logic [DW-1:0]         bus_rdata
);
  localparam logic [AW-1:0] SUM_ADDR = AW'(2 * NCH);

  logic [NCH-1:0] hit_cfg;
  logic [NCH-1:0] hit_st;
  logic [DW-1:0]  rd_d;
  logic [DW-1:0]  rd_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_cfg_t cfg_q;
    chan_cfg_t cfg_d;
    logic      cfg_upd;

    assign hit_cfg[c] = (bus_addr == AW'(2 * c));
    assign hit_st[c]  = (bus_addr == AW'(2 * c + 1));

    always_comb begin
      cfg_upd = bus_we & hit_cfg[c];
      cfg_d   = chan_cfg_t'(bus_wdata[CFG_W-1:0]);
      clr[c]  = (bus_we & hit_st[c]) ? chan_stat_t'(bus_wdata[STAT_W-1:0]) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= '0;
      else if (cfg_upd) cfg_q <= cfg_d;
    end

    assign cfg[c] = cfg_q;
  end

  always_comb begin
    rd_d = '0;
    for (int c = 0; c < NCH; c++) begin
      if (hit_cfg[c]) rd_d = DW'(cfg[c]);
      if (hit_st[c])  rd_d = DW'(stat[c]);
    end
    if (bus_addr == SUM_ADDR) begin
      for (int c = 0; c < NCH; c++) rd_d[c] = |stat[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (bus_re) rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;
endmodule

// File: rtl/link_irq_agg.sv
module link_irq_agg
  import link_irq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       sig_det,
  input  logic [NCH-1:0]       lock_det,
  input  logic [NCH*EYE_W-1:0] eye_h,
  input  logic [NCH*EYE_W-1:0] eye_v,
  input  logic [NCH-1:0]       eye_vld,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 irq_n_oe
);
  chan_cfg_t  [NCH-1:0] cfg_w;
  chan_stat_t [NCH-1:0] clr_w;
  chan_stat_t [NCH-1:0] stat_w;
  logic       [NCH-1:0] eye_en_w;

  link_reg_file #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat      (stat_w),
    .cfg       (cfg_w),
    .clr       (clr_w),
    .bus_rdata (bus_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_mon
    link_chan_mon u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_det  (sig_det[c]),
      .lock_det (lock_det[c]),
      .eye_vld  (eye_vld[c]),
      .eye_h    (eye_h[c*EYE_W +: EYE_W]),
      .eye_v    (eye_v[c*EYE_W +: EYE_W]),
      .cfg      (cfg_w[c]),
      .clr      (clr_w[c]),
      .stat     (stat_w[c])
    );
    assign eye_en_w[c] = cfg_w[c].eye_en;
  end

  assign irq_n_oe = |stat_w;
endmodule

// File: rtl/link_irq_agg_chk.sv
module link_irq_agg_chk
  import link_irq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       sig_det,
  input logic [NCH-1:0]       lock_det,
  input logic                 bus_we,
  input logic [AW-1:0]        bus_addr,
  input logic [DW-1:0]        bus_wdata,
  input logic                 irq_n_oe,
  input chan_stat_t [NCH-1:0] stat,
  input logic [NCH-1:0]       eye_en
);
  logic started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic st_wr;
    assign st_wr = bus_we && (bus_addr == AW'(2 * c + 1));

    // R2
    los_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started_q && $past(sig_det[c]) && !sig_det[c] |=> stat[c].los);

    // R2
    los_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started_q && !$past(sig_det[c]) && !stat[c].los |=> !stat[c].los);

    // R3
    lol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started_q && $past(lock_det[c]) && !lock_det[c] |=> stat[c].lol);

    // R5
    eye_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eye_en[c] && !stat[c].eye |=> !stat[c].eye);

    for (genvar b = 0; b < STAT_W; b++) begin : g_b
      // R7
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[c][b] && !(st_wr && bus_wdata[b]) |=> stat[c][b]);
    end
  end

  // R8
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_oe) |-> $past(bus_we));
endmodule

bind link_irq_agg link_irq_agg_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sig_det   (sig_det),
  .lock_det  (lock_det),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_n_oe  (irq_n_oe),
  .stat      (stat_w),
  .eye_en    (eye_en_w)
);

// File: tb/link_irq_agg_tb.sv
`timescale 1ns/1ps
module link_irq_agg_tb;
  logic        clk;
  logic        rst_n;
  logic [3:0]  sig_det, lock_det, eye_vld;
  logic [31:0] eye_h, eye_v;
  logic        bus_we, bus_re;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_n_oe;

  int nchk = 0;
  int nerr = 0;
  string cur_tag = "R9";

  logic [2:0] m_st  [4];
  logic [7:0] m_hth [4];
  logic [7:0] m_vth [4];
  logic       m_en  [4];
  logic       m_sp  [4];
  logic       m_lp  [4];
  logic       m_bad [4];

  link_irq_agg u_dut (
    .clk, .rst_n, .sig_det, .lock_det, .eye_h, .eye_v, .eye_vld,
    .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata, .irq_n_oe
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [3:0] a);
    logic [31:0] r = '0;
    if (a < 4'd8) begin
      int c = int'(a >> 1);
      if (a[0]) r = {29'd0, m_st[c]};
      else      r = {15'd0, m_en[c], m_vth[c], m_hth[c]};
    end else if (a == 4'd8) begin
      for (int c = 0; c < 4; c++) r[c] = |m_st[c];
    end
    return r;
  endfunction

  function automatic logic model_irq();
    logic x = 1'b0;
    for (int c = 0; c < 4; c++) x |= |m_st[c];
    return x;
  endfunction

  task automatic step();
    logic [31:0] er;
    logic        rd;
    er = model_read(bus_addr);
    rd = bus_re;
    for (int c = 0; c < 4; c++) begin
      logic [2:0] ev, clr;
      logic [7:0] h, v;
      logic       fail;
      h = eye_h[c*8 +: 8];
      v = eye_v[c*8 +: 8];
      fail  = (h < m_hth[c]) || (v < m_vth[c]);
      ev[0] = m_sp[c] & ~sig_det[c];
      ev[1] = m_lp[c] & ~lock_det[c];
      ev[2] = m_en[c] && eye_vld[c] && fail && !m_bad[c];
      if (eye_vld[c]) m_bad[c] = fail;
      m_sp[c] = sig_det[c];
      m_lp[c] = lock_det[c];
      clr = (bus_we && bus_addr == 4'(2*c+1)) ? bus_wdata[2:0] : 3'b000;
      m_st[c] = ev | (m_st[c] & ~clr);
      if (bus_we && bus_addr == 4'(2*c))
        {m_en[c], m_vth[c], m_hth[c]} = bus_wdata[16:0];
    end
    @(posedge clk);
    @(negedge clk);
    if (rd) check(cur_tag, bus_rdata, er);
    check("R8", {31'd0, irq_n_oe}, {31'd0, model_irq()});
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic do_read(logic [3:0] a, logic [31:0] e, string tag);
    bus_re = 1'b1; bus_addr = a; cur_tag = tag;
    step();
    bus_re = 1'b0;
    check(tag, bus_rdata, e);
  endtask

  task automatic set_eye(int c, logic vld, logic [7:0] h, logic [7:0] v);
    eye_vld[c] = vld; eye_h[c*8 +: 8] = h; eye_v[c*8 +: 8] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int c = 0; c < 4; c++) begin
      m_st[c] = 0; m_hth[c] = 0; m_vth[c] = 0; m_en[c] = 0;
      m_sp[c] = 0; m_lp[c] = 0; m_bad[c] = 0;
    end
    rst_n = 1'b0; sig_det = 0; lock_det = 0; eye_vld = 0; eye_h = 0; eye_v = 0;
    bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8", {31'd0, irq_n_oe}, 32'd0);
    do_read(4'd6, 32'd0, "R5");
    do_read(4'd8, 32'd0, "R9");

    // R2: signal low since reset gives no loss
    step(); step();
    do_read(4'd1, 32'd0, "R2");

    // R2/R1/R8: loss of signal on channel 1
    sig_det[1] = 1'b1; step();
    sig_det[1] = 1'b0; step();
    do_read(4'd3, 32'd1, "R2");
    check("R8", {31'd0, irq_n_oe}, 32'd1);
    do_read(4'd8, 32'd2, "R9");
    do_read(4'd1, 32'd0, "R1");
    do_read(4'd5, 32'd0, "R1");

    // R7/R3: event and clear in the same cycle
    lock_det[2] = 1'b1; step();
    lock_det[2] = 1'b0; do_write(4'd5, 32'd2);
    do_read(4'd5, 32'd2, "R7");
    do_write(4'd5, 32'd0);
    do_read(4'd5, 32'd2, "R7");
    do_write(4'd5, 32'd2);
    step(); step();
    do_read(4'd5, 32'd0, "R3");
    do_write(4'd3, 32'd1);
    check("R8", {31'd0, irq_n_oe}, 32'd0);

    // R5: eye alarm disabled
    do_write(4'd6, 32'h0000_3040);
    set_eye(3, 1'b1, 8'h10, 8'h80); step();
    set_eye(3, 1'b0, 8'h10, 8'h80); step();
    do_read(4'd7, 32'd0, "R5");
    set_eye(3, 1'b1, 8'h40, 8'h30); step();
    do_write(4'd6, 32'h0001_3040);
    do_read(4'd6, 32'h0001_3040, "R9");

    // R6: strict compare and edge qualification
    step();
    do_read(4'd7, 32'd0, "R6");
    set_eye(3, 1'b1, 8'h3F, 8'h30); step();
    set_eye(3, 1'b0, 8'h3F, 8'h30);
    do_read(4'd7, 32'd4, "R6");
    do_write(4'd7, 32'd4);
    set_eye(3, 1'b1, 8'h20, 8'h30); step();
    set_eye(3, 1'b0, 8'hFF, 8'hFF); step(); step();
    set_eye(3, 1'b1, 8'h20, 8'h30); step();
    set_eye(3, 1'b0, 8'h20, 8'h30);
    do_read(4'd7, 32'd0, "R6");
    set_eye(3, 1'b1, 8'h80, 8'h80); step();
    set_eye(3, 1'b1, 8'h80, 8'h2F); step();
    set_eye(3, 1'b0, 8'h80, 8'h2F);
    do_read(4'd7, 32'd4, "R6");
    do_write(4'd7, 32'd4);

    // R10: zero thresholds never fail, per channel
    do_write(4'd0, 32'h0001_0000);
    set_eye(0, 1'b1, 8'h00, 8'h00); step();
    set_eye(0, 1'b0, 8'h00, 8'h00);
    do_read(4'd1, 32'd0, "R10");

    // R4: loss still recorded with eye enable set
    do_write(4'd2, 32'h0001_0000);
    sig_det[1] = 1'b1; step();
    sig_det[1] = 1'b0; step();
    do_read(4'd3, 32'd1, "R4");

    // R9: unmapped reads and summary writes
    do_read(4'd15, 32'd0, "R9");
    do_write(4'd8, 32'hFF);
    do_read(4'd8, 32'd2, "R9");
    do_write(4'd3, 32'd7);

    // random phase, scored by the model
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < 4; c++) begin
        if ($urandom_range(7) == 0) sig_det[c]  = ~sig_det[c];
        if ($urandom_range(7) == 0) lock_det[c] = ~lock_det[c];
        eye_vld[c] = ($urandom_range(2) == 0);
        eye_h[c*8 +: 8] = 8'($urandom_range(32, 96));
        eye_v[c*8 +: 8] = 8'($urandom_range(32, 96));
      end
      bus_we = ($urandom_range(5) == 0);
      bus_re = ($urandom_range(2) == 0);
      if ($urandom_range(39) == 0)
        bus_wdata = {15'd0, 1'($urandom_range(1)), 8'($urandom_range(40, 80)), 8'($urandom_range(40, 80))};
      else
        bus_wdata = 32'($urandom_range(7));
      bus_addr = 4'($urandom_range(15));
      cur_tag = "R9";
      step();
    end
    bus_we = 0; bus_re = 0;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule